// File: doc/BRIEF.md
# Mixed-Mode Call/Return Stack Sequencer

This block carries out the stack and program-counter work of control transfers that can move the processor between its 16-bit short address mode and its 24-bit long address mode. It keeps two stack pointers. The short stack pointer is 16 bits wide and addresses memory at a fixed upper page. The long stack pointer is 24 bits wide. Return addresses can be split across the two stacks. A marker byte records the mode of the caller: 02h for short and 03h for long.

A request is taken on a single-cycle `start` together with an operation code, the instruction's width prefix controls, a target or restart vector, the current PC, the current mode and the mixed-mode enable. The sequencer then moves one byte per cycle over a byte-wide memory port. It commits the new PC and mode at the end, and it signals completion together with a pipeline flush request. Operation codes are 0 call, 1 jump, 2 restart, 3 long return, 4 illegal-instruction trap. Codes 5 to 7 are not operations.

The prefix inputs are `sfx_en`, which marks that a width prefix is present, `sfx_reg_long` (the register-width half) and `sfx_imm_long` (the immediate-width half). When no prefix is present, both halves take the current mode.

Top module: `xfer_stack_seq`

## Requirements
- R1: After reset `pc_out` is 000000h, `adl_out` is 0 (short mode), `busy`, `done`, `flush`, `mem_wr` and `mem_rd` are 0, and the stack pointers hold their reset parameters (short 0180h, long 000100h by default).
- R2: A push writes one byte per cycle at the selected pointer minus one, and the pointer is decremented. A multi-byte value is pushed high byte first, so its low byte ends at the lowest address. The short stack address is {page, short pointer}. Only one of `mem_wr`/`mem_rd` is high in any cycle.
- R3: A call enters long mode when `sfx_imm_long` is set with a prefix, or when `adl_in` is set without one. A long target loads all 24 bits of `target` into the PC. A short target loads `target[15:0]` and keeps `pc_in[23:16]`.
- R4: For a call, restart or trap whose resulting mode is short, PC[15:0] goes to the short stack. If the caller was long, PC[23:16] then goes to the long stack. When the resulting mode is long, PC[15:0] goes to the long stack, preceded by PC[23:16] if the caller was long.
- R5: A marker byte of {6'b0, 1, caller mode} (02h short, 03h long) is pushed last on the long stack when the mode changes. It is also pushed for a call that has a prefix, for a restart that has a prefix or has mixed mode enabled, and for a trap that has mixed mode enabled.
- R6: A restart selects long mode from `sfx_reg_long` when a prefix is present, and otherwise from `adl_in`. The PC becomes `target[7:0]` zero-extended to 24 bits in long mode. In short mode it becomes `target[7:0]` zero-extended to 16 bits, with `pc_in[23:16]` kept.
- R7: A trap keeps the mode. It clears the whole PC in long mode and PC[15:0] in short mode.
- R8: A jump selects its mode and PC the way a call does, makes no memory access, leaves both pointers unchanged, and completes in the cycle after it is accepted.
- R9: A long return pops a marker from the long stack, and bit 0 of the marker becomes the new mode. If the current mode is short, a long marker pops PC[23:16] from the long stack and PC[15:0] from the short stack, while a short marker pops PC[15:0] from the short stack. If the current mode is long, the remaining bytes come from the long stack: 3 bytes for a long marker, 2 for a short one. A pop reads at the pointer and then increments it, and read data is taken in the same cycle. A return paired with a marked call restores the caller's PC, mode and both pointers.
- R10: `done` and `flush` are high for exactly one cycle, in the cycle after the final stack access. An n-access operation completes n+1 cycles after the accepting edge. `pc_out` and `adl_out` change only in that cycle.
- R11: `start` is ignored while `busy` is high, including the `done` cycle. Operation codes 5 to 7 are ignored and leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 3 | Operation code |
| sfx_en | input | 1 | Width prefix present |
| sfx_reg_long | input | 1 | Prefix register-width half is long |
| sfx_imm_long | input | 1 | Prefix immediate-width half is long |
| target | input | 24 | Call/jump target or restart vector |
| pc_in | input | 24 | Return PC of the instruction |
| adl_in | input | 1 | Current mode, 1 = long |
| madl_in | input | 1 | Mixed-mode enable |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of `mem_rd` |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| pc_out | output | 24 | Committed PC |
| adl_out | output | 1 | Committed mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| flush | output | 1 | Pipeline flush request |
| sps_out | output | 16 | Short stack pointer |
| spl_out | output | 24 | Long stack pointer |

## Verification
The case of interest is a new request that arrives in the same cycle as the completion pulse of the previous one. The bench raises `start` with a jump to FFFFFFh during the `done` cycle of a call. In the following cycle it requires `busy` to be low and `pc_out` to still hold the call's target. Every call, restart and trap combination that pushes a marker is also run back through a long return, and the restored PC, mode and both pointers are compared with the values computed in the bench before the call.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int PC_W      = 24;
  localparam int SP_S_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int PAGE_W    = PC_W - SP_S_W;
  localparam int MAX_STEPS = 4;
  localparam int STEP_IW   = $clog2(MAX_STEPS);
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  localparam logic [2:0] OP_CALL = 3'd0;
  localparam logic [2:0] OP_JP   = 3'd1;
  localparam logic [2:0] OP_RST  = 3'd2;
  localparam logic [2:0] OP_RETL = 3'd3;
  localparam logic [2:0] OP_TRAP = 3'd4;

  typedef struct packed {
    logic              on_long;
    logic [1:0]        lane;
    logic [BYTE_W-1:0] data;
  } stk_step_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PUSH = 3'd1,
    S_MARK = 3'd2,
    S_POP  = 3'd3,
    S_FIN  = 3'd4
  } seq_state_e;

  function automatic stk_step_t mk_step(logic on_long, logic [1:0] lane,
                                        logic [BYTE_W-1:0] data);
    stk_step_t s;
    s.on_long = on_long;
    s.lane    = lane;
    s.data    = data;
    return s;
  endfunction
endpackage

// File: rtl/xfer_push_plan.sv
module xfer_push_plan
  import xfer_pkg::*;
(
  input  logic [2:0]                        op,
  input  logic                              sfx_en,
  input  logic                              sfx_reg_long,
  input  logic                              sfx_imm_long,
  input  logic [PC_W-1:0]                   target,
  input  logic [PC_W-1:0]                   pc_in,
  input  logic                              adl_in,
  input  logic                              madl_in,
  output stk_step_t [MAX_STEPS-1:0]         steps,
  output logic [CNT_W-1:0]                  n_steps,
  output logic                              tgt_long,
  output logic [PC_W-1:0]                   new_pc,
  output logic                              op_ok,
  output logic                              is_ret
);
  logic mark;
  logic do_push;
  logic [CNT_W-1:0] cnt;
  logic [PAGE_W-1:0] upper;
  logic [BYTE_W-1:0] marker;

  assign upper  = pc_in[PC_W-1:SP_S_W];
  assign marker = {{(BYTE_W-2){1'b0}}, 1'b1, adl_in};

  // operation decode: resulting mode, new PC, marker need
  always_comb begin
    mark     = 1'b0;
    do_push  = 1'b0;
    op_ok    = 1'b1;
    is_ret   = 1'b0;
    tgt_long = adl_in;
    new_pc   = pc_in;
    case (op)
      OP_CALL: begin
        tgt_long = sfx_en ? sfx_imm_long : adl_in;
        mark     = sfx_en;
        do_push  = 1'b1;
        new_pc   = tgt_long ? target : {upper, target[SP_S_W-1:0]};
      end
      OP_JP: begin
        tgt_long = sfx_en ? sfx_imm_long : adl_in;
        new_pc   = tgt_long ? target : {upper, target[SP_S_W-1:0]};
      end
      OP_RST: begin
        tgt_long = sfx_en ? sfx_reg_long : adl_in;
        mark     = sfx_en | madl_in;
        do_push  = 1'b1;
        new_pc   = tgt_long ? PC_W'(target[BYTE_W-1:0])
                            : {upper, SP_S_W'(target[BYTE_W-1:0])};
      end
      OP_TRAP: begin
        mark     = madl_in;
        do_push  = 1'b1;
        new_pc   = adl_in ? '0 : {upper, {SP_S_W{1'b0}}};
      end
      OP_RETL: is_ret = 1'b1;
      default: op_ok = 1'b0;
    endcase
    if (tgt_long != adl_in) mark = 1'b1;
  end

  // ordered push list: high byte first, marker last on the long stack
  always_comb begin
    steps = '0;
    cnt   = '0;
    if (do_push) begin
      if (!tgt_long) begin
        steps[cnt[STEP_IW-1:0]] = mk_step(1'b0, 2'd1, pc_in[15:8]);
        cnt = cnt + 1'b1;
        steps[cnt[STEP_IW-1:0]] = mk_step(1'b0, 2'd0, pc_in[7:0]);
        cnt = cnt + 1'b1;
        if (adl_in) begin
          steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd2, pc_in[23:16]);
          cnt = cnt + 1'b1;
        end
      end else begin
        if (adl_in) begin
          steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd2, pc_in[23:16]);
          cnt = cnt + 1'b1;
        end
        steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd1, pc_in[15:8]);
        cnt = cnt + 1'b1;
        steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd0, pc_in[7:0]);
        cnt = cnt + 1'b1;
      end
      if (mark) begin
        steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd0, marker);
        cnt = cnt + 1'b1;
      end
    end
    n_steps = cnt;
  end
endmodule

// File: rtl/xfer_pop_plan.sv
module xfer_pop_plan
  import xfer_pkg::*;
(
  input  logic                      cur_long,
  input  logic                      mark_long,
  output stk_step_t [MAX_STEPS-1:0] steps,
  output logic [CNT_W-1:0]          n_steps
);
  logic [CNT_W-1:0] cnt;

  // pops low byte first; upper byte on the long stack when marker is long
  always_comb begin
    steps = '0;
    cnt   = '0;
    if (mark_long && !cur_long) begin
      steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd2, '0);
      cnt = cnt + 1'b1;
    end
    steps[cnt[STEP_IW-1:0]] = mk_step(cur_long, 2'd0, '0);
    cnt = cnt + 1'b1;
    steps[cnt[STEP_IW-1:0]] = mk_step(cur_long, 2'd1, '0);
    cnt = cnt + 1'b1;
    if (mark_long && cur_long) begin
      steps[cnt[STEP_IW-1:0]] = mk_step(1'b1, 2'd2, '0);
      cnt = cnt + 1'b1;
    end
    n_steps = cnt;
  end
endmodule

// File: rtl/xfer_stack_ptrs.sv
module xfer_stack_ptrs
  import xfer_pkg::*;
#(
  parameter logic [SP_S_W-1:0] SPS_INIT = 16'h0180,
  parameter logic [PC_W-1:0]   SPL_INIT = 24'h000100,
  parameter logic [PAGE_W-1:0] SPS_PAGE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_pop,
  input  logic              acc_long,
  output logic [PC_W-1:0]   addr,
  output logic [SP_S_W-1:0] sps,
  output logic [PC_W-1:0]   spl
);
  logic [SP_S_W-1:0] sps_q, sps_d;
  logic [PC_W-1:0]   spl_q, spl_d;

  always_comb begin
    sps_d = sps_q;
    spl_d = spl_q;
    if (acc_long) addr = acc_pop ? spl_q : spl_q - 1'b1;
    else          addr = {SPS_PAGE, (acc_pop ? sps_q : sps_q - 1'b1)};
    if (acc_en) begin
      if (acc_long) spl_d = acc_pop ? spl_q + 1'b1 : spl_q - 1'b1;
      else          sps_d = acc_pop ? sps_q + 1'b1 : sps_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sps_q <= SPS_INIT;
      spl_q <= SPL_INIT;
    end else if (acc_en) begin
      sps_q <= sps_d;
      spl_q <= spl_d;
    end
  end

  assign sps = sps_q;
  assign spl = spl_q;
endmodule

// File: rtl/xfer_stack_seq.sv
module xfer_stack_seq
  import xfer_pkg::*;
#(
  parameter logic [SP_S_W-1:0] SPS_INIT = 16'h0180,
  parameter logic [PC_W-1:0]   SPL_INIT = 24'h000100,
  parameter logic [PAGE_W-1:0] SPS_PAGE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              sfx_en,
  input  logic              sfx_reg_long,
  input  logic              sfx_imm_long,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              adl_in,
  input  logic              madl_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [PC_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              adl_out,
  output logic              busy,
  output logic              done,
  output logic              flush,
  output logic [SP_S_W-1:0] sps_out,
  output logic [PC_W-1:0]   spl_out
);
  seq_state_e                state_q, state_d;
  stk_step_t [MAX_STEPS-1:0] steps_q, steps_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d, idx_q, idx_d;
  logic [PC_W-1:0]           acc_q, acc_d, pc_q, pc_d;
  logic                      mode_new_q, mode_new_d, cur_q, cur_d, mode_q, mode_d;

  stk_step_t [MAX_STEPS-1:0] push_steps, pop_steps;
  logic [CNT_W-1:0]          push_n, pop_n;
  logic                      plan_long, plan_ok, plan_ret;
  logic [PC_W-1:0]           plan_pc, pc_merge;
  stk_step_t                 cur_step;
  logic                      last_step;
  logic                      acc_en, acc_pop, acc_long;

  xfer_push_plan i_push_plan (
    .op(op), .sfx_en(sfx_en), .sfx_reg_long(sfx_reg_long),
    .sfx_imm_long(sfx_imm_long), .target(target), .pc_in(pc_in),
    .adl_in(adl_in), .madl_in(madl_in), .steps(push_steps),
    .n_steps(push_n), .tgt_long(plan_long), .new_pc(plan_pc),
    .op_ok(plan_ok), .is_ret(plan_ret)
  );

  xfer_pop_plan i_pop_plan (
    .cur_long(cur_q), .mark_long(mem_rdata[0]),
    .steps(pop_steps), .n_steps(pop_n)
  );

  xfer_stack_ptrs #(
    .SPS_INIT(SPS_INIT), .SPL_INIT(SPL_INIT), .SPS_PAGE(SPS_PAGE)
  ) i_ptrs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_pop(acc_pop),
    .acc_long(acc_long), .addr(mem_addr), .sps(sps_out), .spl(spl_out)
  );

  assign cur_step  = steps_q[idx_q[STEP_IW-1:0]];
  assign last_step = (idx_q == cnt_q - 1'b1);

  // popped byte dropped into its lane of the PC accumulator
  always_comb begin
    pc_merge = acc_q;
    case (cur_step.lane)
      2'd0:    pc_merge[7:0]   = mem_rdata;
      2'd1:    pc_merge[15:8]  = mem_rdata;
      default: pc_merge[23:16] = mem_rdata;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    steps_d    = steps_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    acc_d      = acc_q;
    mode_new_d = mode_new_q;
    cur_d      = cur_q;
    pc_d       = pc_q;
    mode_d     = mode_q;
    mem_wr     = 1'b0;
    mem_rd     = 1'b0;
    acc_en     = 1'b0;
    acc_pop    = 1'b0;
    acc_long   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start && plan_ok) begin
          cur_d      = adl_in;
          steps_d    = push_steps;
          cnt_d      = push_n;
          idx_d      = '0;
          mode_new_d = plan_long;
          if (plan_ret) begin
            acc_d   = pc_in;
            state_d = S_MARK;
          end else if (push_n == '0) begin
            pc_d    = plan_pc;
            mode_d  = plan_long;
            state_d = S_FIN;
          end else begin
            acc_d   = plan_pc;
            state_d = S_PUSH;
          end
        end
      end
      S_PUSH: begin
        mem_wr   = 1'b1;
        acc_en   = 1'b1;
        acc_long = cur_step.on_long;
        idx_d    = idx_q + 1'b1;
        if (last_step) begin
          pc_d    = acc_q;
          mode_d  = mode_new_q;
          state_d = S_FIN;
        end
      end
      S_MARK: begin
        mem_rd     = 1'b1;
        acc_en     = 1'b1;
        acc_pop    = 1'b1;
        acc_long   = 1'b1;
        mode_new_d = mem_rdata[0];
        steps_d    = pop_steps;
        cnt_d      = pop_n;
        idx_d      = '0;
        state_d    = S_POP;
      end
      S_POP: begin
        mem_rd   = 1'b1;
        acc_en   = 1'b1;
        acc_pop  = 1'b1;
        acc_long = cur_step.on_long;
        acc_d    = pc_merge;
        idx_d    = idx_q + 1'b1;
        if (last_step) begin
          pc_d    = pc_merge;
          mode_d  = mode_new_q;
          state_d = S_FIN;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      steps_q    <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      acc_q      <= '0;
      mode_new_q <= 1'b0;
      cur_q      <= 1'b0;
      pc_q       <= '0;
      mode_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      steps_q    <= steps_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      acc_q      <= acc_d;
      mode_new_q <= mode_new_d;
      cur_q      <= cur_d;
      pc_q       <= pc_d;
      mode_q     <= mode_d;
    end
  end

  assign mem_wdata = (state_q == S_PUSH) ? cur_step.data : '0;
  assign pc_out    = pc_q;
  assign adl_out   = mode_q;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign flush     = done;
endmodule

// File: rtl/xfer_stack_seq_chk.sv
module xfer_stack_seq_chk
  import xfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              done,
  input logic              busy,
  input logic [PC_W-1:0]   pc_out,
  input logic              adl_out,
  input logic [SP_S_W-1:0] sps_out,
  input logic [PC_W-1:0]   spl_out
);
  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));

  assert_push_predec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ((spl_out == $past(spl_out) - 24'd1) && (sps_out == $past(sps_out))) ||
               ((sps_out == $past(sps_out) - 16'd1) && (spl_out == $past(spl_out))));

  assert_pop_postinc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ((spl_out == $past(spl_out) + 24'd1) && (sps_out == $past(sps_out))) ||
               ((sps_out == $past(sps_out) + 16'd1) && (spl_out == $past(spl_out))));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pc_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_out != $past(pc_out)) |-> done);

  assert_mode_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adl_out != $past(adl_out)) |-> done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_wr && !mem_rd));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr && !mem_rd));
endmodule

bind xfer_stack_seq xfer_stack_seq_chk i_chk (.*);

// File: tb/test_xfer_stack_seq.sv
`timescale 1ns/1ps
module test_xfer_stack_seq;
  import xfer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sfx_en = 1'b0, sfx_reg_long = 1'b0, sfx_imm_long = 1'b0;
  logic [23:0] target = '0, pc_in = '0;
  logic        adl_in = 1'b0, madl_in = 1'b0;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_wr, mem_rd, adl_out, busy, done, flush;
  logic [23:0] mem_addr, pc_out, spl_out;
  logic [15:0] sps_out;
  logic [7:0]  mem [512];

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xfer_stack_seq i_xfer_stack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sfx_en(sfx_en),
    .sfx_reg_long(sfx_reg_long), .sfx_imm_long(sfx_imm_long),
    .target(target), .pc_in(pc_in), .adl_in(adl_in), .madl_in(madl_in),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_out(pc_out),
    .adl_out(adl_out), .busy(busy), .done(done), .flush(flush),
    .sps_out(sps_out), .spl_out(spl_out)
  );

  always @(posedge clk) if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[8:0]];

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic s, input logic rl,
                        input logic il, input logic [23:0] tg,
                        input logic [23:0] pcv, input logic a, input logic m,
                        output int lat, output logic fl);
    @(negedge clk);
    op = o; sfx_en = s; sfx_reg_long = rl; sfx_imm_long = il;
    target = tg; pc_in = pcv; adl_in = a; madl_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    fl = flush;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat;
    logic fl;
    logic [15:0] sps0;
    logic [23:0] spl0, pcv, tg, exp_pc, hold_pc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pc", 32'(pc_out), 32'h0);
    check("R1", "mode", 32'(adl_out), 32'h0);
    check("R1", "busy/done/flush", 32'({busy, done, flush, mem_wr, mem_rd}), 32'h0);
    check("R1", "sps", 32'(sps_out), 32'h0180);
    check("R1", "spl", 32'(spl_out), 32'h000100);
    rst_n = 1'b1;
    @(negedge clk);

    // R3..R7, R9: sweep of call, restart and trap
    for (int k = 0; k < 3; k++) begin
      for (int a = 0; a < 2; a++) begin
        for (int s = 0; s < 2; s++) begin
          for (int x = 0; x < 2; x++) begin
            for (int m = 0; m < 2; m++) begin
              logic [2:0] o;
              logic tl, mk;
              int ns, nl;
              o = (k == 0) ? OP_CALL : (k == 1) ? OP_RST : OP_TRAP;
              pcv = 24'hA15C3B ^ 24'({k[1:0], a[0], s[0], x[0], m[0]});
              tg = 24'h7E4D21 + 24'({a[0], x[0]});
              tl = (k == 2) ? a[0] : (s[0] ? x[0] : a[0]);
              mk = (tl != a[0]) || ((k == 0) ? s[0] : (k == 1) ? (s[0] | m[0]) : m[0]);
              ns = tl ? 0 : 2;
              nl = (tl ? (a[0] ? 3 : 2) : (a[0] ? 1 : 0)) + (mk ? 1 : 0);
              if (k == 0)      exp_pc = tl ? tg : {pcv[23:16], tg[15:0]};
              else if (k == 1) exp_pc = tl ? {16'h0, tg[7:0]} : {pcv[23:16], 8'h0, tg[7:0]};
              else             exp_pc = a[0] ? 24'h0 : {pcv[23:16], 16'h0};
              sps0 = sps_out; spl0 = spl_out;
              run_op(o, s[0], x[0], x[0], tg, pcv, a[0], m[0], lat, fl);
              check(k == 0 ? "R3" : k == 1 ? "R6" : "R7", "pc", 32'(pc_out), 32'(exp_pc));
              check(k == 2 ? "R7" : "R3", "mode", 32'(adl_out), 32'(tl));
              check("R4", "sps drop", 32'(sps0 - sps_out), 32'(ns));
              check("R4", "spl drop", 32'(spl0 - spl_out), 32'(nl));
              check("R10", "latency", 32'(lat), 32'(ns + nl + 1));
              check("R10", "flush", 32'(fl), 32'h1);
              if (ns == 2) check("R2", "sps low byte", 32'(mem[{1'b1, sps_out[7:0]}]), 32'(pcv[7:0]));
              if (mk) begin
                check("R5", "marker", 32'(mem[spl_out[8:0]]), 32'({7'b0000001, a[0]}));
                if (tl) check("R2", "spl low byte", 32'(mem[9'(spl_out[8:0] + 9'd1)]), 32'(pcv[7:0]));
                run_op(OP_RETL, 1'b1, 1'b1, 1'b1, 24'h0, {pcv[23:16], 16'h1234},
                       tl, m[0], lat, fl);
                check("R9", "return pc", 32'(pc_out), 32'(pcv));
                check("R9", "return mode", 32'(adl_out), 32'(a[0]));
                check("R9", "return sps", 32'(sps_out), 32'(sps0));
                check("R9", "return spl", 32'(spl_out), 32'(spl0));
                check("R10", "return latency", 32'(lat), 32'(ns + nl + 1));
              end
            end
          end
        end
      end
    end

    // R8 jump sweep
    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 2; s++) begin
        for (int x = 0; x < 2; x++) begin
          logic tl;
          pcv = 24'h3C0000 + 24'({a[0], s[0], x[0]});
          tg = 24'h51A2B3 ^ 24'({x[0], s[0], a[0]});
          tl = s[0] ? x[0] : a[0];
          exp_pc = tl ? tg : {pcv[23:16], tg[15:0]};
          sps0 = sps_out; spl0 = spl_out;
          run_op(OP_JP, s[0], 1'b0, x[0], tg, pcv, a[0], 1'b0, lat, fl);
          check("R8", "pc", 32'(pc_out), 32'(exp_pc));
          check("R8", "mode", 32'(adl_out), 32'(tl));
          check("R8", "latency", 32'(lat), 32'h1);
          check("R8", "pointers", 32'({sps_out, spl_out[15:0]}), 32'({sps0, spl0[15:0]}));
        end
      end
    end

    // R11 start during the done cycle is ignored
    @(negedge clk);
    op = OP_CALL; sfx_en = 1'b0; target = 24'h123456; pc_in = 24'h654321;
    adl_in = 1'b1; madl_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    op = OP_JP; target = 24'hFFFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11", "busy after start in done", 32'(busy), 32'h0);
    check("R11", "pc after start in done", 32'(pc_out), 32'h123456);

    // R11 unsupported operation codes
    for (int c = 5; c < 8; c++) begin
      hold_pc = pc_out; sps0 = sps_out; spl0 = spl_out;
      @(negedge clk);
      op = 3'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R11", "busy on bad op", 32'({busy, done}), 32'h0);
      @(negedge clk);
      check("R11", "state on bad op", 32'({pc_out, adl_out}), 32'({hold_pc, 1'b1}));
      check("R11", "ptrs on bad op", 32'({sps_out, spl_out[15:0]}), 32'({sps0, spl0[15:0]}));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule